// File: doc/BRIEF.md
# Accumulator Instruction Processor

This block is a small stored-program processor with a single accumulator. One word-addressed memory holds both code and data. Every instruction passes through the same fetch sequence. The program counter goes to the memory address register. The memory word comes back into the memory data register and moves on to the instruction register. The program counter then steps by one, and the opcode selects an execute sequence. Each execute sequence moves data through the same two registers. There are no shortcuts, so each instruction takes a known, fixed number of clock cycles.

A word is 16 bits. The opcode sits in bits 15:12 and the operand in bits 11:0. The operand is either a memory address or a device number. The opcode values are:

- 0: no operation
- 1: load
- 2: add
- 3: store
- 4: subtract
- 5: input
- 6: output
- 7: halt
- 8: jump
- 9: skip if zero
- 10: skip if positive
- 11: skip if negative
- 12 to 15: halt

Arithmetic is 16-bit two's complement. Three flags (zero, positive, negative) describe the last value written into the accumulator by a load, add, subtract or input. Input uses a valid handshake and waits as long as needed. Output gives a one-cycle strobe together with the device number; device numbers are 5 for keyboard, 7 for printer and 9 for screen.

The memory outside the block reads synchronously, with one cycle of latency. It writes on the clock edge where the write enable is high.

Top module: `acc_core`

## Requirements
- R1: While reset is low, `halted`, `mem_we`, `out_stb` and `in_req` are low. After reset is released, the first fetch reads address `START_ADDR`.
- R2: Every instruction begins with a 5-cycle fetch. In cycle 1 of that fetch, `mem_addr` holds the program counter. The program counter then advances by one (modulo 4096) before the execute sequence starts.
- R3: Load (1), add (2) and subtract (4) take 9 cycles in total. In cycle 6 of the instruction they present the operand address. They then set the accumulator to the memory word, to accumulator + word, or to accumulator − word, each wrapping at 16 bits.
- R4: Store (3) takes 8 cycles. `mem_we` is high for exactly cycle 7 of the instruction, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator.
- R5: Load, add, subtract and input set exactly one flag from the value written to the accumulator: zero when it is 0, negative when bit 15 is set, and positive otherwise. All other instructions leave the flags unchanged.
- R6: Skip-if-zero (9), skip-if-positive (10) and skip-if-negative (11) take 5 cycles. When their flag is set, they advance the program counter by one more, which skips the next word.
- R7: Jump (8) takes 5 cycles and loads the program counter with the 12-bit operand.
- R8: Input (5) holds `in_req` high from cycle 5 of the instruction, with `in_dev` equal to the operand. It waits until a cycle in which `in_valid` is high, loads `in_data` into the accumulator in that cycle, and then ends.
- R9: Output (6) takes 6 cycles. `out_stb` is high only in cycle 5 of the instruction, with `out_dev` equal to the operand and `out_data` equal to the accumulator.
- R10: Opcodes 7 and 12 to 15 raise `halted` from cycle 5 of the instruction. After that, the core never writes memory, never strobes the output and never requests input until reset.
- R11: Opcode 0 takes 5 cycles and changes nothing except the program-counter step made by the fetch.
- R12: With 1245 at address 0, 1755 at address 1, and the instructions load 0, add 1, store 2, halt at addresses 3 to 6, starting from address 3 leaves 3000 at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| in_req | output | 1 | Input instruction is waiting for data |
| in_dev | output | ADDR_W | Device number selected for input |
| in_valid | input | 1 | `in_data` is valid this cycle |
| in_data | input | DATA_W | Value from the input device |
| out_stb | output | 1 | One-cycle output strobe |
| out_dev | output | ADDR_W | Device number selected for output |
| out_data | output | DATA_W | Accumulator value being output |
| halted | output | 1 | Core has stopped |

## Verification
The bench aims at the flag corner cases. It exercises 0x8000 minus one becoming positive, 0x7FFF plus one wrapping to negative, and two negatives summing to zero. A core that derived its flags from a carry, or that let store change the flags, would take the wrong skip, and its fetch addresses would drift away from the schedule. An input delayed by several cycles checks that the core waits rather than loading stale data; loading too early would change the product computed by the multiply loop. Opcode 12 halting, opcode 0 running as a no-operation, and exact strobe cycles are compared on every clock. A mistake in any of them shows up as a write, strobe or halt in the wrong cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OP_W = 4;

  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_NOP   = 4'd0;
  localparam op_t OP_LOAD  = 4'd1;
  localparam op_t OP_ADD   = 4'd2;
  localparam op_t OP_STORE = 4'd3;
  localparam op_t OP_SUB   = 4'd4;
  localparam op_t OP_IN    = 4'd5;
  localparam op_t OP_OUT   = 4'd6;
  localparam op_t OP_JMP   = 4'd8;
  localparam op_t OP_SKZ   = 4'd9;
  localparam op_t OP_SKG   = 4'd10;
  localparam op_t OP_SKL   = 4'd11;

  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_RD,  ST_F_MDR, ST_F_IR,  ST_DEC,
    ST_M_MAR, ST_M_RD,  ST_M_MDR, ST_M_ALU,
    ST_S_MAR, ST_S_MDR, ST_S_WR,
    ST_IN,    ST_OUT,   ST_HALT
  } st_e;

  typedef struct packed {
    logic z;
    logic g;
    logic l;
  } flags_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_t               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output flags_t            fl
);

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      default: res = b;
    endcase
  end

  always_comb begin
    fl.z = (res == '0);
    fl.l = res[DATA_W-1];
    fl.g = !fl.z && !fl.l;
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_t  op,
  input  logic in_valid,
  output st_e  state
);

  st_e state_n;

  always_comb begin
    state_n = state;
    case (state)
      ST_F_MAR: state_n = ST_F_RD;
      ST_F_RD:  state_n = ST_F_MDR;
      ST_F_MDR: state_n = ST_F_IR;
      ST_F_IR:  state_n = ST_DEC;
      ST_DEC: begin
        case (op)
          OP_LOAD, OP_ADD, OP_SUB:          state_n = ST_M_MAR;
          OP_STORE:                         state_n = ST_S_MAR;
          OP_IN:                            state_n = ST_IN;
          OP_OUT:                           state_n = ST_OUT;
          OP_NOP, OP_JMP, OP_SKZ, OP_SKG,
          OP_SKL:                           state_n = ST_F_MAR;
          default:                          state_n = ST_HALT;
        endcase
      end
      ST_M_MAR: state_n = ST_M_RD;
      ST_M_RD:  state_n = ST_M_MDR;
      ST_M_MDR: state_n = ST_M_ALU;
      ST_M_ALU: state_n = ST_F_MAR;
      ST_S_MAR: state_n = ST_S_MDR;
      ST_S_MDR: state_n = ST_S_WR;
      ST_S_WR:  state_n = ST_F_MAR;
      ST_IN:    state_n = in_valid ? ST_F_MAR : ST_IN;
      ST_OUT:   state_n = ST_F_MAR;
      ST_HALT:  state_n = ST_HALT;
      default:  state_n = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_F_MAR;
    else        state <= state_n;
  end

  // R10: the stopped state is never left without reset
  p_halt_absorb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT);

  // R2: dispatch is always preceded by the instruction-register load
  p_dec_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_F_IR |=> state == ST_DEC);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int START_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              in_req,
  output logic [ADDR_W-1:0] in_dev,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_stb,
  output logic [ADDR_W-1:0] out_dev,
  output logic [DATA_W-1:0] out_data,
  output logic              halted
);

  localparam int OPF_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_ADDR);
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  st_e               state;
  logic [ADDR_W-1:0] pc_q,  pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic [DATA_W-1:0] ir_q,  ir_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  flags_t            fl_q,  fl_d;
  logic pc_en, mar_en, mdr_en, ir_en, acc_en, fl_en;

  op_t               op;
  logic [ADDR_W-1:0] opnd;
  logic [DATA_W-1:0] alu_b, alu_res;
  flags_t            alu_fl;
  logic              skip_take;

  assign op   = op_t'(ir_q[DATA_W-1 -: OPF_W]);
  assign opnd = ir_q[ADDR_W-1:0];

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .in_valid (in_valid),
    .state    (state)
  );

  assign alu_b = (state == ST_IN) ? in_data : mdr_q;

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (op),
    .a   (acc_q),
    .b   (alu_b),
    .res (alu_res),
    .fl  (alu_fl)
  );

  always_comb begin
    case (op)
      OP_SKZ:  skip_take = fl_q.z;
      OP_SKG:  skip_take = fl_q.g;
      OP_SKL:  skip_take = fl_q.l;
      default: skip_take = 1'b0;
    endcase
  end

  // next-state values and clock enables for the data path
  always_comb begin
    pc_d  = pc_q;  pc_en  = 1'b0;
    mar_d = mar_q; mar_en = 1'b0;
    mdr_d = mdr_q; mdr_en = 1'b0;
    ir_d  = ir_q;  ir_en  = 1'b0;
    acc_d = acc_q; acc_en = 1'b0;
    fl_d  = fl_q;  fl_en  = 1'b0;
    case (state)
      ST_F_MAR: begin mar_d = pc_q; mar_en = 1'b1; end
      ST_F_MDR, ST_M_MDR: begin mdr_d = mem_rdata; mdr_en = 1'b1; end
      ST_F_IR: begin
        ir_d = mdr_q;          ir_en = 1'b1;
        pc_d = pc_q + PC_ONE;  pc_en = 1'b1;
      end
      ST_DEC: begin
        if (op == OP_JMP) begin
          pc_d = opnd; pc_en = 1'b1;
        end else if (skip_take) begin
          pc_d = pc_q + PC_ONE; pc_en = 1'b1;
        end
      end
      ST_M_MAR, ST_S_MAR: begin mar_d = opnd; mar_en = 1'b1; end
      ST_M_ALU: begin
        acc_d = alu_res; acc_en = 1'b1;
        fl_d  = alu_fl;  fl_en  = 1'b1;
      end
      ST_S_MDR: begin mdr_d = acc_q; mdr_en = 1'b1; end
      ST_IN: begin
        if (in_valid) begin
          acc_d = alu_res; acc_en = 1'b1;
          fl_d  = alu_fl;  fl_en  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC_RST;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      fl_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (acc_en) acc_q <= acc_d;
      if (fl_en)  fl_q  <= fl_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = (state == ST_S_WR);
  assign in_req    = (state == ST_IN);
  assign in_dev    = opnd;
  assign out_stb   = (state == ST_OUT);
  assign out_dev   = opnd;
  assign out_data  = acc_q;
  assign halted    = (state == ST_HALT);

  // R4: a write lasts exactly one cycle
  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R9: the output strobe is a single-cycle pulse
  p_out_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |=> !out_stb);

  // R8: an unanswered input request is held
  p_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !in_valid) |=> (in_req && $stable(acc_q)));

  // R10: a stopped core stays stopped and quiet
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && !out_stb && !in_req));

  // R5: at most one flag is set
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_q.z, fl_q.g, fl_q.l}));

  // R5: stores, outputs and skips do not disturb the flags
  p_flags_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || out_stb || state == ST_DEC) |=> $stable(fl_q));

  // R2: the program counter steps by one at dispatch
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_F_IR |=> pc_q == $past(pc_q) + PC_ONE);

endmodule

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int START = 3;
  localparam int MAXC = 3000;
  localparam int MW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          in_req;
  logic [AW-1:0] in_dev;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_stb;
  logic [AW-1:0] out_dev;
  logic [DW-1:0] out_data;
  logic          halted;

  always #2 clk = ~clk;

  acc_core #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(START)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata),
    .in_req(in_req), .in_dev(in_dev), .in_valid(in_valid), .in_data(in_data),
    .out_stb(out_stb), .out_dev(out_dev), .out_data(out_data),
    .halted(halted)
  );

  logic [DW-1:0] mem [0:MW-1];
  logic [DW-1:0] im  [0:MW-1];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  // expected per-cycle schedule
  logic          e_av [0:MAXC-1];
  logic [AW-1:0] e_a  [0:MAXC-1];
  logic          e_we [0:MAXC-1];
  logic [AW-1:0] e_wa [0:MAXC-1];
  logic [DW-1:0] e_wd [0:MAXC-1];
  logic          e_os [0:MAXC-1];
  logic [AW-1:0] e_od [0:MAXC-1];
  logic [DW-1:0] e_ov [0:MAXC-1];
  logic          e_ir [0:MAXC-1];
  logic [AW-1:0] e_id [0:MAXC-1];
  int            halt_at;

  int in_vals[$];
  int in_wait[$];

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  bit active = 1'b0;
  int ik = 0;
  int wcnt = 0;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errs++;
    $display("FAIL %s %s cycle %0d act %0h exp %0h", req, what, cyc, act, exp);
  endtask

  // behavioural instruction-level model producing the cycle schedule
  task automatic build();
    logic [DW-1:0] a, w;
    logic [AW-1:0] pc, x;
    logic z, g, l;
    int t, k, wt;
    a = '0; pc = AW'(START); z = 0; g = 0; l = 0; t = 0; k = 0;
    halt_at = -1;
    for (int c = 0; c < MAXC; c++) begin
      e_av[c] = 0; e_a[c] = '0; e_we[c] = 0; e_wa[c] = '0; e_wd[c] = '0;
      e_os[c] = 0; e_od[c] = '0; e_ov[c] = '0; e_ir[c] = 0; e_id[c] = '0;
    end
    for (int n = 0; n < 400 && halt_at < 0; n++) begin
      e_av[t+1] = 1; e_a[t+1] = pc;
      w = im[pc[7:0]];
      pc = pc + 1'b1;
      x = w[11:0];
      case (w[15:12])
        4'd1, 4'd2, 4'd4: begin
          e_av[t+6] = 1; e_a[t+6] = x;
          if (w[15:12] == 4'd1)      a = im[x[7:0]];
          else if (w[15:12] == 4'd2) a = a + im[x[7:0]];
          else                       a = a - im[x[7:0]];
          z = (a == 0); l = a[15]; g = !z && !l;
          t += 9;
        end
        4'd3: begin
          e_we[t+7] = 1; e_wa[t+7] = x; e_wd[t+7] = a;
          im[x[7:0]] = a;
          t += 8;
        end
        4'd5: begin
          wt = in_wait[k];
          a = DW'(in_vals[k]);
          k++;
          for (int j = 0; j <= wt; j++) begin e_ir[t+5+j] = 1; e_id[t+5+j] = x; end
          z = (a == 0); l = a[15]; g = !z && !l;
          t += 6 + wt;
        end
        4'd6: begin
          e_os[t+5] = 1; e_od[t+5] = x; e_ov[t+5] = a;
          t += 6;
        end
        4'd8: begin pc = x; t += 5; end
        4'd9:  begin if (z) pc = pc + 1'b1; t += 5; end
        4'd10: begin if (g) pc = pc + 1'b1; t += 5; end
        4'd11: begin if (l) pc = pc + 1'b1; t += 5; end
        4'd0: t += 5;
        default: halt_at = t + 5;
      endcase
    end
  endtask

  // per-cycle comparison and input-device driver, away from the active edge
  always @(negedge clk) begin
    if (active && cyc < MAXC) begin
      vecs++;
      if (e_av[cyc] && mem_addr !== e_a[cyc]) fail("R2/R3", "mem_addr", int'(mem_addr), int'(e_a[cyc]));
      if (mem_we !== e_we[cyc]) fail("R4", "mem_we", int'(mem_we), int'(e_we[cyc]));
      if (e_we[cyc] && (mem_addr !== e_wa[cyc] || mem_wdata !== e_wd[cyc]))
        fail("R4", "write addr/data", int'({mem_addr, mem_wdata}), int'({e_wa[cyc], e_wd[cyc]}));
      if (out_stb !== e_os[cyc]) fail("R9", "out_stb", int'(out_stb), int'(e_os[cyc]));
      if (e_os[cyc] && (out_dev !== e_od[cyc] || out_data !== e_ov[cyc]))
        fail("R9 R5", "out dev/data", int'({out_dev, out_data}), int'({e_od[cyc], e_ov[cyc]}));
      if (in_req !== e_ir[cyc]) fail("R8", "in_req", int'(in_req), int'(e_ir[cyc]));
      if (e_ir[cyc] && in_dev !== e_id[cyc]) fail("R8", "in_dev", int'(in_dev), int'(e_id[cyc]));
      if (halted !== (halt_at >= 0 && cyc >= halt_at))
        fail("R10", "halted", int'(halted), int'(halt_at >= 0 && cyc >= halt_at));
      if (in_req) begin
        if (wcnt == in_wait[ik]) begin
          in_valid = 1'b1;
          in_data  = DW'(in_vals[ik]);
          ik++;
        end else begin
          in_valid = 1'b0;
        end
        wcnt++;
      end else begin
        in_valid = 1'b0;
        wcnt = 0;
      end
      cyc++;
    end
  end

  task automatic run(input string name);
    rst_n = 1'b0;
    active = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vecs++;
    if (halted !== 1'b0 || mem_we !== 1'b0 || out_stb !== 1'b0 || in_req !== 1'b0)
      fail("R1", "reset outputs", int'({halted, mem_we, out_stb, in_req}), 0);
    for (int i = 0; i < MW; i++) im[i] = mem[i];
    build();
    ik = 0; wcnt = 0; cyc = 0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    active = 1'b1;
    while (cyc < halt_at + 20 && cyc < MAXC - 1) @(posedge clk);
    @(negedge clk);
    active = 1'b0;
    for (int i = 0; i < MW; i++) begin
      vecs++;
      if (mem[i] !== im[i]) fail("R4", {name, " final memory"}, int'(mem[i]), int'(im[i]));
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) mem[i] = '0;
    in_vals.delete();
    in_wait.delete();
  endtask

  initial begin
    // R12 R3 R4 R1: sum example, fetch starts at address 3
    clear_mem();
    mem[0] = 16'd1245; mem[1] = 16'd1755;
    mem[3] = 16'h1000; mem[4] = 16'h2001; mem[5] = 16'h3002; mem[6] = 16'h7000;
    run("sum");
    vecs++;
    if (mem[2] !== 16'd3000) fail("R12", "sum result", int'(mem[2]), 3000);

    // R8 R6 R7 R9: multiply by repeated addition with a delayed input
    clear_mem();
    mem[3]  = 16'h5005; mem[4]  = 16'h3028; mem[5]  = 16'h5005; mem[6]  = 16'h3029;
    mem[7]  = 16'h102A; mem[8]  = 16'h2028; mem[9]  = 16'h302A; mem[10] = 16'h1029;
    mem[11] = 16'h402B; mem[12] = 16'h3029; mem[13] = 16'h9000; mem[14] = 16'h8007;
    mem[15] = 16'h102A; mem[16] = 16'h6009; mem[17] = 16'h7000;
    mem[43] = 16'd1;
    in_vals.push_back(6); in_wait.push_back(0);
    in_vals.push_back(4); in_wait.push_back(3);
    run("mult");
    vecs++;
    if (mem[42] !== 16'd24) fail("R8", "product", int'(mem[42]), 24);

    // R5 R6 R7 R10 R11: wrap, sign flags, flags kept across store, nop, opcode 12
    clear_mem();
    mem[3]  = 16'h1032; mem[4]  = 16'hB000; mem[5]  = 16'h6007; mem[6]  = 16'hA000;
    mem[7]  = 16'h6007; mem[8]  = 16'h4033; mem[9]  = 16'h9000; mem[10] = 16'h3034;
    mem[11] = 16'hA000; mem[12] = 16'h7000; mem[13] = 16'h0000; mem[14] = 16'h2033;
    mem[15] = 16'hB000; mem[16] = 16'h7000; mem[17] = 16'h6009; mem[18] = 16'h2035;
    mem[19] = 16'h9000; mem[20] = 16'h7000; mem[21] = 16'h8017; mem[22] = 16'h7000;
    mem[23] = 16'hC123;
    mem[50] = 16'h8000; mem[51] = 16'h0001; mem[53] = 16'h8000;
    run("flags");
    vecs++;
    if (mem[52] !== 16'h7FFF) fail("R5", "wrapped difference", int'(mem[52]), 16'h7FFF);

    // R8 R5 R10: zero from input sets the zero flag, opcode 15 halts
    clear_mem();
    mem[3] = 16'h5009; mem[4] = 16'h9000; mem[5] = 16'h7000; mem[6] = 16'h6005;
    mem[7] = 16'hF000;
    in_vals.push_back(0); in_wait.push_back(1);
    run("inzero");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL R10 watchdog expired act 0 exp 1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule